// File: doc/BRIEF.md
# Shared-Unit ODE Integration Step

This block advances a second-order differential-equation solver by one integration step. From the present state `x`, `y`, `u`, the step size `dx` and a bound `a`, all signed 16-bit fixed point with eight fraction bits, it produces the next `x`, `y` and `u`. It also raises a flag that tells whether the new `x` is still below the bound. The equations run as a fixed four-step schedule. Only two multipliers and two add/subtract/compare units do the work, and each unit is reused in every control step under a binding table held in the package.

A one-cycle `start` pulse captures the operands and starts the schedule. After the fourth control step the results appear on the outputs and `done` pulses for one cycle. In loop mode the block writes the new state back as its own operands and runs another step with no gap for as long as the compare flag stays set. The caller sees one `done` pulse per step, and the final state once the flag clears.

Top module: `ode_step`

## Requirements
- R1: The new x is x + dx, in 16-bit two's-complement arithmetic that wraps on overflow.
- R2: The new y is y + m(u, dx). Here m(p, q) is the signed 32-bit product p·q with bits [23:8] kept as the 16-bit result.
- R3: The new u is u − m(m(3, x), m(u, dx)) − m(m(3, y), dx), where the constant 3 is 0x0300. Both subtractions wrap in 16 bits.
- R4: The output c is 1 exactly when the new x, as a signed value, is less than a.
- R5: `start` is sampled on a rising edge while the block is idle. `done` is then high only in the cycle after the fifth rising edge from that sample edge, and only for one cycle.
- R6: `x_o`, `y_o`, `u_o` and `c_o` change only at the edge that raises `done`. They hold while the inputs change without a new start.
- R7: A `start` pulse that arrives while a step is in progress is ignored, together with the operand values presented with it.
- R8: If `loop_en` is 1 when a step ends with c = 1, the new x, y and u become the next operands. The next step begins at once, so the next `done` follows four cycles later. Iteration stops after the first step that ends with c = 0.
- R9: A synchronous active-high reset returns the controller to idle, clears `done`, and clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a step (taken only while idle) |
| loop_en | input | 1 | Keep stepping while the compare flag is set |
| x_i | input | 16 | Present x, signed Q8.8 |
| y_i | input | 16 | Present y, signed Q8.8 |
| u_i | input | 16 | Present u, signed Q8.8 |
| dx_i | input | 16 | Step size, signed Q8.8 |
| a_i | input | 16 | Bound for the compare, signed Q8.8 |
| x_o | output | 16 | New x |
| y_o | output | 16 | New y |
| u_o | output | 16 | New u |
| c_o | output | 1 | New x below bound |
| done_o | output | 1 | One-cycle pulse when a step's results are on the outputs |

## Verification
After a `start` drive, the results and `done` of a single step are due five clock cycles later. Each later step in loop mode is due four cycles after the previous `done`. The bench drives and samples on the falling edge and counts falling edges from the start drive. It checks that `done` appears on exactly the expected count and stays low before it and in the cycle after it, and it compares all four results in the `done` cycle against a bench model. Hold checks sample the outputs over several cycles with no start, and busy-start checks inject a second start two cycles into a step.

// File: rtl/ode_pkg.sv
`timescale 1ns/1ps
package ode_pkg;
    localparam int W     = 16;
    localparam int FRAC  = 8;
    localparam int NMUL  = 2;
    localparam int NALU  = 2;
    localparam int NUNIT = NMUL + NALU;

    typedef logic signed [W-1:0]   q_t;
    typedef logic signed [2*W-1:0] qw_t;

    localparam q_t K_THREE = q_t'(3 <<< FRAC);

    // register-file slots; I_K3 reads the constant 3.0, I_NONE is a spare slot
    typedef enum logic [3:0] {
        I_X, I_Y, I_U, I_DX, I_A, I_3X, I_UDX, I_XN,
        I_P, I_3Y, I_C, I_Q, I_UDX2, I_UT, I_K3, I_NONE
    } idx_e;

    typedef enum logic [1:0] {OP_ADD, OP_SUB, OP_LT} op_e;

    typedef enum logic [2:0] {ST_IDLE, ST_S1, ST_S2, ST_S3, ST_S4} st_e;

    typedef struct packed {
        logic en;
        idx_e sa;
        idx_e sb;
        idx_e dst;
        op_e  op;
    } uctl_t;

    // units 0..NMUL-1 are multipliers, the rest are ALUs
    typedef uctl_t [NUNIT-1:0] bind_t;

    function automatic q_t qmul(input q_t a, input q_t b);
        qw_t p;
        p = qw_t'(a) * qw_t'(b);
        return q_t'(p >>> FRAC);
    endfunction

    function automatic q_t alu_eval(input op_e op, input q_t a, input q_t b);
        case (op)
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            OP_LT:   return (a < b) ? q_t'(1) : q_t'(0);
            default: return '0;
        endcase
    endfunction

    function automatic uctl_t mk(input idx_e sa, input idx_e sb, input idx_e dst, input op_e op);
        uctl_t u;
        u.en = 1'b1; u.sa = sa; u.sb = sb; u.dst = dst; u.op = op;
        return u;
    endfunction

    // fixed schedule and binding, one row per control step
    function automatic bind_t bind_of(input st_e s);
        bind_t b;
        for (int k = 0; k < NUNIT; k++) b[k] = '{en: 1'b0, sa: I_NONE, sb: I_NONE, dst: I_NONE, op: OP_ADD};
        case (s)
            ST_S1: begin
                b[0] = mk(I_K3, I_X,  I_3X,  OP_ADD);
                b[1] = mk(I_U,  I_DX, I_UDX, OP_ADD);
                b[2] = mk(I_X,  I_DX, I_XN,  OP_ADD);
            end
            ST_S2: begin
                b[0] = mk(I_3X, I_UDX, I_P,  OP_ADD);
                b[1] = mk(I_K3, I_Y,   I_3Y, OP_ADD);
                b[2] = mk(I_XN, I_A,   I_C,  OP_LT);
            end
            ST_S3: begin
                b[0] = mk(I_3Y, I_DX, I_Q,    OP_ADD);
                b[1] = mk(I_U,  I_DX, I_UDX2, OP_ADD);
                b[3] = mk(I_U,  I_P,  I_UT,   OP_SUB);
            end
            ST_S4: begin
                b[2] = mk(I_Y,  I_UDX2, I_Y, OP_ADD);
                b[3] = mk(I_UT, I_Q,    I_U, OP_SUB);
            end
            default: ;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/ode_ctrl.sv
`timescale 1ns/1ps
module ode_ctrl
    import ode_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic loop_en,
    input  logic c_now,
    output st_e  st,
    output logic done
);
    st_e st_n;

    always_comb begin
        st_n = st;
        case (st)
            ST_IDLE: if (start) st_n = ST_S1;
            ST_S1:   st_n = ST_S2;
            ST_S2:   st_n = ST_S3;
            ST_S3:   st_n = ST_S4;
            ST_S4:   st_n = (loop_en && c_now) ? ST_S1 : ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            done <= 1'b0;
        end else begin
            st   <= st_n;
            done <= (st == ST_S4);
        end
    end

    assert_done_after_s4_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(st) == ST_S4);
    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_s1_to_s2_R5: assert property (@(posedge clk) disable iff (rst)
        st == ST_S1 |=> st == ST_S2);
    assert_busy_start_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_S2 && start) |=> st == ST_S3);
    assert_loop_cont_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_S4 && loop_en && c_now) |=> st == ST_S1);
endmodule

// File: rtl/ode_unit.sv
`timescale 1ns/1ps
module ode_unit
    import ode_pkg::*;
#(
    parameter bit IS_MUL = 1'b1
)(
    input  op_e op,
    input  q_t  a,
    input  q_t  b,
    output q_t  y
);
    generate
        if (IS_MUL) begin : g_mul
            op_e op_unused;
            assign op_unused = op;
            assign y = qmul(a, b);
        end else begin : g_alu
            assign y = alu_eval(op, a, b);
        end
    endgenerate
endmodule

// File: rtl/ode_step.sv
`timescale 1ns/1ps
module ode_step
    import ode_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         loop_en,
    input  logic [15:0]  x_i,
    input  logic [15:0]  y_i,
    input  logic [15:0]  u_i,
    input  logic [15:0]  dx_i,
    input  logic [15:0]  a_i,
    output logic [15:0]  x_o,
    output logic [15:0]  y_o,
    output logic [15:0]  u_o,
    output logic         c_o,
    output logic         done_o
);
    localparam int NREG = 1 << $bits(idx_e);

    st_e   st;
    bind_t bnd;
    q_t    rf  [NREG];
    q_t    res [NUNIT];
    logic  c_now;
    logic  load;

    function automatic q_t src(input idx_e i);
        return (i == I_K3) ? K_THREE : rf[i];
    endfunction

    assign bnd   = bind_of(st);
    assign c_now = rf[I_C][0];
    assign load  = (st == ST_IDLE) && start;

    ode_ctrl i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .loop_en (loop_en),
        .c_now   (c_now),
        .st      (st),
        .done    (done_o)
    );

    generate
        for (genvar g = 0; g < NUNIT; g++) begin : g_units
            ode_unit #(.IS_MUL(g < NMUL)) i_unit (
                .op (bnd[g].op),
                .a  (src(bnd[g].sa)),
                .b  (src(bnd[g].sb)),
                .y  (res[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NREG; k++) rf[k] <= '0;
        end else if (load) begin
            rf[I_X]  <= q_t'(x_i);
            rf[I_Y]  <= q_t'(y_i);
            rf[I_U]  <= q_t'(u_i);
            rf[I_DX] <= q_t'(dx_i);
            rf[I_A]  <= q_t'(a_i);
        end else begin
            for (int k = 0; k < NUNIT; k++)
                if (bnd[k].en) rf[bnd[k].dst] <= res[k];
            if (st == ST_S4) rf[I_X] <= rf[I_XN];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_o <= '0;
            y_o <= '0;
            u_o <= '0;
            c_o <= 1'b0;
        end else if (st == ST_S4) begin
            x_o <= rf[I_XN];
            y_o <= res[NMUL];
            u_o <= res[NMUL+1];
            c_o <= rf[I_C][0];
        end
    end

    assert_hold_outputs_R6: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(x_o) && $stable(y_o) && $stable(u_o) && $stable(c_o)));
    assert_compare_flag_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> c_o == ($signed(x_o) < $signed(rf[I_A])));
    assert_x_written_back_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> rf[I_X] == q_t'(x_o));
endmodule

// File: tb/test_ode_step.sv
`timescale 1ns/1ps
module test_ode_step;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        loop_en = 1'b0;
    logic [15:0] x_i = '0, y_i = '0, u_i = '0, dx_i = '0, a_i = '0;
    logic [15:0] x_o, y_o, u_o;
    logic        c_o, done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ode_step i_ode_step (
        .clk(clk), .rst(rst), .start(start), .loop_en(loop_en),
        .x_i(x_i), .y_i(y_i), .u_i(u_i), .dx_i(dx_i), .a_i(a_i),
        .x_o(x_o), .y_o(y_o), .u_o(u_o), .c_o(c_o), .done_o(done_o)
    );

    function automatic logic [15:0] bm(input logic [15:0] p, input logic [15:0] q);
        logic signed [31:0] r;
        r = $signed({{16{p[15]}}, p}) * $signed({{16{q[15]}}, q});
        return r[23:8];
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one or more steps; poke injects a busy start with different operands
    task automatic run(input logic [15:0] x, input logic [15:0] y, input logic [15:0] u,
                       input logic [15:0] dx, input logic [15:0] a, input bit lp, input bit poke);
        logic [15:0] mx, my, mu, xn, yn, un;
        logic mc;
        int cnt, gap, iters;
        @(negedge clk);
        x_i = x; y_i = y; u_i = u; dx_i = dx; a_i = a; loop_en = lp; start = 1'b1;
        mx = x; my = y; mu = u;
        cnt = 0; gap = 5; iters = 0;
        while (1) begin
            @(negedge clk);
            cnt++;
            start = 1'b0;
            if (poke && cnt == 2) begin
                start = 1'b1;
                x_i = x ^ 16'h5a5a; y_i = y + 16'h0100; u_i = ~u; dx_i = dx + 16'h0040;
            end
            if (done_o) begin
                xn = mx + dx;
                mc = $signed(xn) < $signed(a);
                yn = my + bm(mu, dx);
                un = mu - bm(bm(16'h0300, mx), bm(mu, dx)) - bm(bm(16'h0300, my), dx);
                chk(lp ? "R8 done spacing" : "R5 done latency", 16'(cnt), 16'(gap));
                chk(poke ? "R7 R1 x after busy start" : "R1 new x", x_o, xn);
                chk("R2 new y", y_o, yn);
                chk("R3 new u", u_o, un);
                chk("R4 compare flag", {15'd0, c_o}, {15'd0, mc});
                iters++;
                if (lp && mc && iters < 40) begin
                    mx = xn; my = yn; mu = un; cnt = 0; gap = 4;
                end else break;
            end else if (cnt > 30) begin
                chk("R5 done never seen", 16'd0, 16'd1);
                break;
            end
        end
        @(negedge clk);
        chk("R5 done single cycle", {15'd0, done_o}, 16'd0);
        loop_en = 1'b0;
    endtask

    initial begin
        logic [15:0] hx, hy, hu;
        logic hc;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 reset x", x_o, 16'd0);
        chk("R9 reset y", y_o, 16'd0);
        chk("R9 reset u", u_o, 16'd0);
        chk("R9 reset c/done", {14'd0, c_o, done_o}, 16'd0);

        // directed corners
        run(16'h0100, 16'h0200, 16'h0080, 16'h0010, 16'h0400, 1'b0, 1'b0);
        run(16'h7f00, 16'h0000, 16'h0000, 16'h0200, 16'h0000, 1'b0, 1'b0); // R1 wrap
        run(16'hff00, 16'h8000, 16'h7fff, 16'hff80, 16'h8000, 1'b0, 1'b0); // negatives
        run(16'h0100, 16'h0100, 16'h0100, 16'h0000, 16'h0100, 1'b0, 1'b0); // R4 equal: c=0
        run(16'h0100, 16'h0300, 16'hfe00, 16'h0020, 16'h0800, 1'b0, 1'b1); // R7

        // R6 hold without start
        hx = x_o; hy = y_o; hu = u_o; hc = c_o;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            x_i = 16'($urandom); y_i = 16'($urandom); u_i = 16'($urandom); dx_i = 16'($urandom);
        end
        chk("R6 hold x", x_o, hx);
        chk("R6 hold y", y_o, hy);
        chk("R6 hold u", u_o, hu);
        chk("R6 hold c/done", {14'd0, c_o, done_o}, {14'd0, hc, 1'b0});

        // R8 loop mode: x 0 -> 1 -> 2 -> 3 against bound 3.0, three steps
        run(16'h0000, 16'h0040, 16'h0020, 16'h0100, 16'h0300, 1'b1, 1'b0);
        // R8 loop mode where the first step already clears the flag
        run(16'h0500, 16'h0010, 16'h0010, 16'h0100, 16'h0200, 1'b1, 1'b0);

        // constrained random single steps, some with busy starts
        for (int n = 0; n < 24; n++) begin
            run(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom_range(0, 16'h03ff)),
                16'($urandom), 1'b0, n[2]);
        end

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule